// File: doc/BRIEF.md
# Masked Clear-on-Read Interrupt Controller

This block gathers sixteen single-cycle event pulses from a radio core into two 8-bit status registers. Each status register has an 8-bit mask register beside it. An active-low interrupt line is driven low while any latched event is also enabled. Software reaches all four registers through a plain register port. The port has an address, write data, a write strobe, a read strobe and a registered read-data output.

Reading a status register returns its contents and clears only the bits whose mask bit is set. A masked event stays latched, so it remains visible to later reads, but it never pulls the interrupt line low. Once reset is released, the block raises its own power-on event. That event is enabled out of reset, so the interrupt line falls soon after start-up.

Top module: `evt_irq_ctrl`

## Requirements
- R1: A one-cycle high on an event input sets its status bit at the next clock edge. Status register A holds `evt_i[7:0]`: bit 7 FIFO error, bit 6 TX FIFO almost full, bit 5 TX FIFO almost empty, bit 4 RX FIFO almost full, bit 3 external, bit 2 packet sent, bit 1 packet valid, bit 0 CRC error. Status register B holds `evt_i[15:8]`: bit 7 sync word found, bit 6 preamble valid, bit 5 preamble invalid, bit 4 RSSI, bit 3 wake-up timer, bit 2 low battery, bit 1 chip ready, bit 0 power-on.
- R2: Status A is read at address 03h and status B at 04h. Mask A is read and written at 05h and mask B at 06h, and a bit set to 1 enables that event. A write takes effect at the clock edge of the strobe. Read data appears on `rdata_o` one cycle after the read strobe and holds until the next read.
- R3: While reset is high, mask A is 00h, mask B is 01h, `rdata_o` is 00h and `irq_n_o` is 1.
- R4: A read of a status address clears every bit of that register whose mask bit is 1.
- R5: A status bit whose mask bit is 0 keeps its value through reads and never drives `irq_n_o` low.
- R6: An event that arrives in the same cycle as a clearing read leaves its status bit set. The read returns the value from before the clear.
- R7: `irq_n_o` is registered. In each cycle it equals the inverse of the OR of (status AND mask) over both registers, as those values stood one cycle earlier.
- R8: The power-on status bit (B bit 0) is set at the first clock edge after reset is released, and `irq_n_o` falls at the edge after that.
- R9: Writes to 03h or 04h have no effect on any register.
- R10: A read of any address other than 03h to 06h returns 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 16 | Event pulses: [7:0] go to status A, [15:8] go to status B |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
Some properties are checked on every cycle:
- an event always lands in its status bit;
- masked bits survive any read, and enabled bits are gone after a read that carries no new event;
- the interrupt line tracks the masked status one cycle late;
- writes to the status addresses change nothing;
- unmapped reads return zero;
- the power-on bit appears right after reset.

Other behaviour is shown only by the bench's scenarios, where a cycle-by-cycle model is compared against the outputs:
- the exact bit position of each event;
- the value read back when an event collides with a clearing read;
- the mask values after reset;
- how mask writes interact with later clears.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned BANKS     = 2;
  localparam int unsigned STAT_BASE = 3;
  localparam int unsigned MASK_BASE = 5;
  localparam int unsigned POR_IDX   = REG_W;
  typedef logic [REG_W-1:0] reg_t;
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] MASK_RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wd_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         pend_o
);
  logic [W-1:0] stat_q, mask_q, clr_vec;

  assign clr_vec = clr_i ? mask_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= MASK_RST;
    end else begin
      stat_q <= (stat_q & ~clr_vec) | evt_i;
      if (mask_we_i) mask_q <= mask_wd_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = |(stat_q & mask_q);

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R1
  AST_MASKED_KEPT: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((stat_q & $past(stat_q & ~mask_q)) == $past(stat_q & ~mask_q))); // R5
  AST_CLEAR_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (clr_i && evt_i == '0) |=> ((stat_q & $past(mask_q)) == '0)); // R4
endmodule

// File: rtl/evt_read_mux.sv
module evt_read_mux #(
  parameter int unsigned W     = 8,
  parameter int unsigned AW    = 8,
  parameter int unsigned NB    = 2,
  parameter int unsigned SBASE = 3,
  parameter int unsigned MBASE = 5
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [NB*W-1:0] stat_i,
  input  logic [NB*W-1:0] mask_i,
  output logic [W-1:0]    data_o
);
  always_comb begin
    data_o = '0;
    for (int b = 0; b < NB; b++) begin
      if (addr_i == AW'(SBASE + b)) data_o = stat_i[b*W +: W];
      if (addr_i == AW'(MBASE + b)) data_o = mask_i[b*W +: W];
    end
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int unsigned DATA_W  = evt_irq_pkg::REG_W,
  parameter int unsigned NUM_BNK = evt_irq_pkg::BANKS,
  parameter int unsigned ADDR_W  = 8,
  parameter logic [NUM_BNK*DATA_W-1:0] MASK_RST_ALL = 16'h0100
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_BNK*DATA_W-1:0]   evt_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic                        wr_i,
  input  logic                        rd_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic                        irq_n_o
);
  import evt_irq_pkg::*;
  localparam int unsigned TOT_W = NUM_BNK * DATA_W;

  logic               por_pend_q;
  logic [TOT_W-1:0]   evt_all, stat_all, mask_all;
  logic [NUM_BNK-1:0] pend;
  logic [DATA_W-1:0]  rd_sel;

  always_comb begin
    evt_all = evt_i;
    evt_all[POR_IDX] = evt_i[POR_IDX] | por_pend_q;
  end

  for (genvar b = 0; b < NUM_BNK; b++) begin : g_bank
    logic clr, mwe;
    assign clr = rd_i && (addr_i == ADDR_W'(STAT_BASE + b));
    assign mwe = wr_i && (addr_i == ADDR_W'(MASK_BASE + b));
    evt_status_bank #(
      .W(DATA_W), .MASK_RST(MASK_RST_ALL[b*DATA_W +: DATA_W])
    ) u_bank (
      .clk(clk), .rst(rst),
      .evt_i(evt_all[b*DATA_W +: DATA_W]),
      .clr_i(clr), .mask_we_i(mwe), .mask_wd_i(wdata_i),
      .stat_o(stat_all[b*DATA_W +: DATA_W]),
      .mask_o(mask_all[b*DATA_W +: DATA_W]),
      .pend_o(pend[b])
    );
  end

  evt_read_mux #(
    .W(DATA_W), .AW(ADDR_W), .NB(NUM_BNK),
    .SBASE(STAT_BASE), .MBASE(MASK_BASE)
  ) u_rmux (
    .addr_i(addr_i), .stat_i(stat_all), .mask_i(mask_all), .data_o(rd_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      por_pend_q <= 1'b1;
      rdata_o    <= '0;
      irq_n_o    <= 1'b1;
    end else begin
      por_pend_q <= 1'b0;
      if (rd_i) rdata_o <= rd_sel;
      irq_n_o <= ~(|pend);
    end
  end

  logic stat_addr, mapped;
  assign stat_addr = (addr_i >= ADDR_W'(STAT_BASE)) && (addr_i < ADDR_W'(STAT_BASE + NUM_BNK));
  assign mapped = stat_addr ||
    ((addr_i >= ADDR_W'(MASK_BASE)) && (addr_i < ADDR_W'(MASK_BASE + NUM_BNK)));

  AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_n_o == !$past(|(stat_all & mask_all)))); // R7
  AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_i && stat_addr && !rd_i && evt_all == '0) |=>
      ($stable(stat_all) && $stable(mask_all))); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !mapped) |=> (rdata_o == '0)); // R10
  AST_POR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> stat_all[POR_IDX]); // R8
endmodule

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;
  logic        clk = 0, rst = 1;
  logic [15:0] evt = '0;
  logic [7:0]  addr = '0, wdata = '0, rdata;
  logic        wr = 0, rd = 0, irq_n;
  int checks = 0, fails = 0;
  string tag = "R3";
  bit live = 0;

  always #10 clk = ~clk;

  evt_irq_ctrl i_evt_irq_ctrl (
    .clk(clk), .rst(rst), .evt_i(evt), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .irq_n_o(irq_n));

  logic [7:0] m_st [2];
  logic [7:0] m_en [2];
  logic [7:0] m_rd;
  logic       m_irq, m_por;

  always @(posedge clk) begin
    if (rst) begin
      m_st[0] = 0; m_st[1] = 0; m_en[0] = 8'h00; m_en[1] = 8'h01;
      m_rd = 0; m_irq = 1; m_por = 1;
    end else begin
      logic [7:0] sel;
      m_irq = !(|(m_st[0] & m_en[0]) || |(m_st[1] & m_en[1]));
      case (addr)
        8'h03: sel = m_st[0];
        8'h04: sel = m_st[1];
        8'h05: sel = m_en[0];
        8'h06: sel = m_en[1];
        default: sel = 0;
      endcase
      if (rd) m_rd = sel;
      for (int b = 0; b < 2; b++) begin
        logic [7:0] e;
        e = evt[b*8 +: 8];
        if (b == 1 && m_por) e[0] = 1;
        if (rd && addr == 8'(3 + b)) m_st[b] = m_st[b] & ~m_en[b];
        m_st[b] = m_st[b] | e;
      end
      if (wr && addr == 8'h05) m_en[0] = wdata;
      if (wr && addr == 8'h06) m_en[1] = wdata;
      m_por = 0;
    end
  end

  always @(negedge clk) if (live) begin
    checks++;
    if (rdata !== m_rd) begin
      fails++;
      $display("FAIL %s rdata actual=%h expected=%h t=%0t", tag, rdata, m_rd, $time);
    end
    checks++;
    if (irq_n !== m_irq) begin
      fails++;
      $display("FAIL %s irq_n actual=%b expected=%b t=%0t", tag, irq_n, m_irq, $time);
    end
  end

  task automatic step(input logic [15:0] e, input logic [7:0] a,
                      input logic [7:0] d, input logic w, input logic r);
    @(negedge clk);
    evt = e; addr = a; wdata = d; wr = w; rd = r;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic rd_reg(input logic [7:0] a);
    step(0, a, 0, 0, 1);
    step(0, 0, 0, 0, 0);
  endtask

  task automatic expect_rd(input logic [7:0] exp, input string t);
    @(negedge clk);
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s directed actual=%h expected=%h", t, rdata, exp);
    end
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    live = 1; tag = "R3";
    idle(2);
    step(0, 8'h06, 0, 0, 1); rst = 0;   // R3: reset mask B reads 01h once out of reset
    tag = "R8";
    step(0, 0, 0, 0, 0);
    expect_rd(8'h01, "R3");
    idle(3);
    tag = "R4"; rd_reg(8'h04);          // clears enabled power-on bit
    idle(2);
    tag = "R2";
    step(0, 8'h05, 8'hA5, 1, 0);
    step(0, 8'h06, 8'h3C, 1, 0);
    rd_reg(8'h05); rd_reg(8'h06);
    step(0, 8'h05, 8'h00, 1, 0);
    step(0, 8'h06, 8'h00, 1, 0);
    tag = "R1";
    for (int i = 0; i < 16; i++) begin
      step(16'(1) << i, 0, 0, 0, 0);
      idle(1);
      rd_reg(i < 8 ? 8'h03 : 8'h04);
    end
    tag = "R5";
    rd_reg(8'h03); rd_reg(8'h04); idle(2);
    tag = "R4";
    step(0, 8'h05, 8'h0F, 1, 0);
    step(0, 8'h06, 8'hF0, 1, 0);
    idle(2);
    rd_reg(8'h03); rd_reg(8'h03); rd_reg(8'h04); rd_reg(8'h04);
    tag = "R6";
    step(16'h0001, 0, 0, 0, 0);
    step(16'h0001, 8'h03, 0, 0, 1);
    idle(1); rd_reg(8'h03); rd_reg(8'h03);
    tag = "R9";
    step(0, 8'h03, 8'hFF, 1, 0);
    step(0, 8'h04, 8'h00, 1, 0);
    rd_reg(8'h03); rd_reg(8'h04); rd_reg(8'h05);
    tag = "R10";
    rd_reg(8'h00); rd_reg(8'h07); rd_reg(8'hFF); rd_reg(8'h02);
    tag = "R7";
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = 8'($urandom_range(2, 7));
      step(($urandom % 4 == 0) ? 16'($urandom) : 16'h0, a, 8'($urandom),
           $urandom % 5 == 0, $urandom % 3 == 0);
    end
    idle(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule